// File: doc/BRIEF.md
# Mailbox Interrupt Status Controller

This block gathers interrupt causes for a host processor into one 32-bit status word and gates them through a matching 32-bit enable word. Both words are reached through a single-cycle register port: a write takes effect on the clock edge, and a read returns the addressed word combinationally. The block drives one level-sensitive host interrupt line.

The status word holds two kinds of cause. Eight sticky bits record that the local side has written one of eight outbound mailboxes. Each stays set until the host writes a one to it. Four further bits show, live, error flags that are owned by a separate configuration status register. These mirror bits can be cleared only by clearing that register, never through this block. Each enable bit masks the status bit at the same position. The interrupt is the registered OR of all status bits whose enable bit is set.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all eight sticky bits read 0, the enable word reads 0, and `irq_o` is 0.
- R2: A pulse on `mbx_wr_evt[n]` (n = 0..7) sets status bit 16+n at the next clock edge. The bit then stays set with no further stimulus.
- R3: A register write to offset 0x040 clears each status bit 16+n whose write-data bit 16+n is 1. A write-data bit of 0 leaves the status bit unchanged.
- R4: If a mailbox event and a clearing write hit the same bit in the same cycle, the bit is 1 after the edge.
- R5: Status bits 10, 11, 12 and 13 read the present value of `cfg_err_flags[0]` to `cfg_err_flags[3]` (target abort received, master abort received, system error signaled, parity error detected) in the same cycle.
- R6: A status write with ones in bits 13:10 does not change the read value of those bits, which keep following `cfg_err_flags`.
- R7: Bits 9:0, 15:14 and 31:24 of both words always read 0. Writes to those bits have no effect, and they never raise the interrupt.
- R8: A write to offset 0x050 loads bits 13:10 and 23:16 of the enable word from the write data, and a read at 0x050 returns them.
- R9: `irq_o` in the cycle after an edge equals the OR, over all bits, of status AND enable as they stood before that edge. It therefore falls one cycle after the last enabled pending bit is cleared or masked.
- R10: A read at any offset other than 0x040 and 0x050 returns 0, and a write there changes neither word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 12 | Register port byte offset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| mbx_wr_evt | input | 8 | One strobe per outbound mailbox, high for a cycle when it is written |
| cfg_err_flags | input | 4 | Live error flags owned by the configuration status register |
| irq_o | output | 1 | Level host interrupt, registered |

## Verification
The assertions assume that `cfg_err_flags` and the register port inputs change only between clock edges and are free of X after reset. They also assume that a mailbox strobe means one write event in the cycle it is high, so a strobe held high for several cycles re-sets its bit on every edge. The stimulus changes every input on the falling edge and holds it for a whole cycle. It samples results a quarter period after the rising edge, while the inputs of that cycle are still present, so the combinational read data reflects the state just written.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

  // Which word a register port offset selects.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_EN   = 2'd2
  } reg_sel_e;

  localparam int unsigned DEF_ADDR_W   = 12;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_NUM_MBX  = 8;
  localparam int unsigned DEF_MBX_LSB  = 16;
  localparam int unsigned DEF_NUM_ERR  = 4;
  localparam int unsigned DEF_ERR_LSB  = 10;
  localparam int unsigned DEF_STAT_OFS = 12'h040;
  localparam int unsigned DEF_EN_OFS   = 12'h050;

endpackage

// File: rtl/mbx_irq_decode.sv
module mbx_irq_decode
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned STAT_OFS = DEF_STAT_OFS,
  parameter int unsigned EN_OFS   = DEF_EN_OFS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output reg_sel_e          sel,
  output logic              stat_wr_hit,
  output logic              en_wr_hit
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);

  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
    if (a == STAT_A)    return SEL_STAT;
    else if (a == EN_A) return SEL_EN;
    else                return SEL_NONE;
  endfunction

  always_comb begin
    sel         = decode_offset(addr);
    stat_wr_hit = wr_en && (sel == SEL_STAT);
    en_wr_hit   = wr_en && (sel == SEL_EN);
  end

endmodule

// File: rtl/mbx_irq_status.sv
module mbx_irq_status
  import mbx_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned NUM_MBX = DEF_NUM_MBX,
  parameter int unsigned MBX_LSB = DEF_MBX_LSB,
  parameter int unsigned NUM_ERR = DEF_NUM_ERR,
  parameter int unsigned ERR_LSB = DEF_ERR_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MBX-1:0] set_vec,
  input  logic [NUM_MBX-1:0] clr_vec,
  input  logic [NUM_ERR-1:0] err_flags,
  output logic [NUM_MBX-1:0] sticky_q,
  output logic [DATA_W-1:0]  status_vec
);

  localparam int unsigned MBX_MSB = MBX_LSB + NUM_MBX - 1;
  localparam int unsigned ERR_MSB = ERR_LSB + NUM_ERR - 1;

  // Next value of one sticky bit: a new event outranks a clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  for (genvar n = 0; n < NUM_MBX; n++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q[n] <= 1'b0;
      else        sticky_q[n] <= sticky_next(sticky_q[n], set_vec[n], clr_vec[n]);
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_map
    if (b >= MBX_LSB && b <= MBX_MSB) begin : g_mbx
      assign status_vec[b] = sticky_q[b - MBX_LSB];
    end else if (b >= ERR_LSB && b <= ERR_MSB) begin : g_err
      assign status_vec[b] = err_flags[b - ERR_LSB];
    end else begin : g_rsvd
      assign status_vec[b] = 1'b0;
    end
  end

endmodule

// File: rtl/mbx_irq_enable.sv
module mbx_irq_enable
  import mbx_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned NUM_MBX = DEF_NUM_MBX,
  parameter int unsigned MBX_LSB = DEF_MBX_LSB,
  parameter int unsigned NUM_ERR = DEF_NUM_ERR,
  parameter int unsigned ERR_LSB = DEF_ERR_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);

  // Positions that hold a real cause; every other bit is reserved.
  function automatic logic [DATA_W-1:0] impl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if ((b >= MBX_LSB && b < MBX_LSB + NUM_MBX) ||
          (b >= ERR_LSB && b < ERR_LSB + NUM_ERR))
        m[b] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] IMPL = impl_mask();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_hit) en_q <= wdata & IMPL;
  end

endmodule

// File: rtl/mbx_irq_combine.sv
module mbx_irq_combine
  import mbx_irq_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] status_vec,
  input  logic [DATA_W-1:0] en_q,
  output logic              pend_any,
  output logic              irq_q
);

  function automatic logic any_enabled(input logic [DATA_W-1:0] s, input logic [DATA_W-1:0] e);
    return |(s & e);
  endfunction

  assign pend_any = any_enabled(status_vec, en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_any;
  end

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_MBX  = DEF_NUM_MBX,
  parameter int unsigned MBX_LSB  = DEF_MBX_LSB,
  parameter int unsigned NUM_ERR  = DEF_NUM_ERR,
  parameter int unsigned ERR_LSB  = DEF_ERR_LSB,
  parameter int unsigned STAT_OFS = DEF_STAT_OFS,
  parameter int unsigned EN_OFS   = DEF_EN_OFS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr_en,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_MBX-1:0] mbx_wr_evt,
  input  logic [NUM_ERR-1:0] cfg_err_flags,
  output logic               irq_o
);

  // Named internal events, visible to the bound checker.
  reg_sel_e           sel;
  logic               stat_wr_hit;
  logic               en_wr_hit;
  logic [NUM_MBX-1:0] set_vec;
  logic [NUM_MBX-1:0] clr_vec;
  logic [NUM_MBX-1:0] sticky_q;
  logic [DATA_W-1:0]  status_vec;
  logic [DATA_W-1:0]  en_q;
  logic               pend_any;

  mbx_irq_decode #(
    .ADDR_W   (ADDR_W),
    .STAT_OFS (STAT_OFS),
    .EN_OFS   (EN_OFS)
  ) u_decode (
    .addr        (reg_addr),
    .wr_en       (reg_wr_en),
    .sel         (sel),
    .stat_wr_hit (stat_wr_hit),
    .en_wr_hit   (en_wr_hit)
  );

  assign set_vec = mbx_wr_evt;
  assign clr_vec = stat_wr_hit ? reg_wdata[MBX_LSB +: NUM_MBX] : '0;

  mbx_irq_status #(
    .DATA_W  (DATA_W),
    .NUM_MBX (NUM_MBX),
    .MBX_LSB (MBX_LSB),
    .NUM_ERR (NUM_ERR),
    .ERR_LSB (ERR_LSB)
  ) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .err_flags  (cfg_err_flags),
    .sticky_q   (sticky_q),
    .status_vec (status_vec)
  );

  mbx_irq_enable #(
    .DATA_W  (DATA_W),
    .NUM_MBX (NUM_MBX),
    .MBX_LSB (MBX_LSB),
    .NUM_ERR (NUM_ERR),
    .ERR_LSB (ERR_LSB)
  ) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (en_wr_hit),
    .wdata  (reg_wdata),
    .en_q   (en_q)
  );

  mbx_irq_combine #(
    .DATA_W (DATA_W)
  ) u_combine (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_vec (status_vec),
    .en_q       (en_q),
    .pend_any   (pend_any),
    .irq_q      (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: reg_rdata = status_vec;
      SEL_EN:   reg_rdata = en_q;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_MBX  = 8,
  parameter int unsigned MBX_LSB  = 16,
  parameter int unsigned NUM_ERR  = 4,
  parameter int unsigned ERR_LSB  = 10,
  parameter int unsigned STAT_OFS = 12'h040,
  parameter int unsigned EN_OFS   = 12'h050
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr_en,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [NUM_MBX-1:0] mbx_wr_evt,
  input logic [NUM_ERR-1:0] cfg_err_flags,
  input logic               irq_o,
  input logic               stat_wr_hit,
  input logic               en_wr_hit,
  input logic [DATA_W-1:0]  status_vec,
  input logic [DATA_W-1:0]  en_q
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);

  function automatic logic [DATA_W-1:0] live_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W; b++)
      if ((b >= MBX_LSB && b < MBX_LSB + NUM_MBX) || (b >= ERR_LSB && b < ERR_LSB + NUM_ERR))
        m[b] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] LIVE = live_mask();

  logic [NUM_MBX-1:0] stat_mbx;
  assign stat_mbx = status_vec[MBX_LSB +: NUM_MBX];

  AST_MBX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_wr_evt != '0) |=> ((stat_mbx & $past(mbx_wr_evt)) == $past(mbx_wr_evt))); // R2
  AST_MBX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr_hit && mbx_wr_evt == '0) |=> $stable(stat_mbx)); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_hit |=> ((stat_mbx & $past(reg_wdata[MBX_LSB +: NUM_MBX] & ~mbx_wr_evt)) == '0)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_hit && ((reg_wdata[MBX_LSB +: NUM_MBX] & mbx_wr_evt) != '0))
      |=> ((stat_mbx & $past(mbx_wr_evt)) != '0)); // R4
  AST_MIRROR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == STAT_A) |-> (reg_rdata[ERR_LSB +: NUM_ERR] == cfg_err_flags)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata & ~LIVE) == '0)); // R7
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_hit |=> (en_q == ($past(reg_wdata) & LIVE))); // R8
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status_vec & en_q)))); // R9
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past((status_vec & en_q) == '0)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != STAT_A && reg_addr != EN_A) |-> (reg_rdata == '0)); // R10
  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr != EN_A) |=> $stable(en_q)); // R10

endmodule

bind mbx_irq_ctrl mbx_irq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_MBX  (NUM_MBX),
  .MBX_LSB  (MBX_LSB),
  .NUM_ERR  (NUM_ERR),
  .ERR_LSB  (ERR_LSB),
  .STAT_OFS (STAT_OFS),
  .EN_OFS   (EN_OFS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_addr      (reg_addr),
  .reg_wr_en     (reg_wr_en),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .mbx_wr_evt    (mbx_wr_evt),
  .cfg_err_flags (cfg_err_flags),
  .irq_o         (irq_o),
  .stat_wr_hit   (stat_wr_hit),
  .en_wr_hit     (en_wr_hit),
  .status_vec    (status_vec),
  .en_q          (en_q)
);

// File: tb/mbx_irq_ctrl_tb.sv
module mbx_irq_ctrl_tb;

  localparam int CLK_P = 10;
  localparam logic [11:0] A_STAT = 12'h040;
  localparam logic [11:0] A_EN   = 12'h050;
  localparam logic [31:0] LIVE   = 32'h00FF_3C00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  mbx_wr_evt = '0;
  logic [3:0]  cfg_err_flags = '0;
  logic        irq_o;

  always #(CLK_P/2) clk = ~clk;

  mbx_irq_ctrl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wr_en     (reg_wr_en),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .mbx_wr_evt    (mbx_wr_evt),
    .cfg_err_flags (cfg_err_flags),
    .irq_o         (irq_o)
  );

  typedef struct {
    logic [31:0] rdata;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  logic [7:0]  m_sticky = '0;
  logic [31:0] m_en     = '0;

  // Status word rebuilt from the requirement text, bit by bit.
  function automatic logic [31:0] m_status(input logic [7:0] st, input logic [3:0] er);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < 8; i++) w[16 + i] = st[i];
    for (int i = 0; i < 4; i++) w[10 + i] = er[i];
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one bus cycle, model update, expected item for the monitor.
  task automatic cyc(input bit wr, input logic [11:0] addr, input logic [31:0] wd,
                     input logic [7:0] evt, input logic [3:0] err, input string tag);
    logic [7:0]  clr;
    logic        old_irq;
    exp_t        it;
    @(negedge clk);
    reg_wr_en     = wr;
    reg_addr      = addr;
    reg_wdata     = wd;
    mbx_wr_evt    = evt;
    cfg_err_flags = err;
    old_irq = (m_status(m_sticky, err) & m_en) != '0;
    clr = (wr && addr == A_STAT) ? wd[23:16] : 8'h00;
    m_sticky = evt | (m_sticky & ~clr);
    if (wr && addr == A_EN) m_en = wd & LIVE;
    if (addr == A_STAT)    it.rdata = m_status(m_sticky, err);
    else if (addr == A_EN) it.rdata = m_en;
    else                   it.rdata = '0;
    it.irq = old_irq;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: samples a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check({it.tag, " rdata"}, reg_rdata, it.rdata);
        check({it.tag, " irq"}, {31'b0, irq_o}, {31'b0, it.irq});
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    reg_addr = A_STAT;
    #1 check("R1 status in reset", reg_rdata, 32'h0);
    check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    reg_addr = A_EN;
    #1 check("R1 enable in reset", reg_rdata, 32'h0);
    rst_n = 1'b1;
    cyc(0, A_STAT, 0, 8'h00, 4'h0, "R1 status after reset");
    cyc(0, A_EN,   0, 8'h00, 4'h0, "R1 enable after reset");

    // R2: sticky set
    cyc(0, A_STAT, 0, 8'h01, 4'h0, "R2 mbx0 sets bit16");
    cyc(0, A_STAT, 0, 8'h00, 4'h0, "R2 bit16 holds");
    cyc(0, A_STAT, 0, 8'h00, 4'h0, "R2 bit16 still holds");

    // R8/R7: enable load with reserved bits masked
    cyc(1, A_EN,   32'hFFFF_FFFF, 8'h00, 4'h0, "R8 enable load all ones");
    cyc(0, A_EN,   0, 8'h00, 4'h0, "R7 enable reserved read zero");
    cyc(0, A_STAT, 0, 8'h00, 4'h0, "R9 irq from enabled mbx0");

    // R3: write-one-to-clear
    cyc(1, A_STAT, 32'h0000_0000, 8'h00, 4'h0, "R3 zero write keeps bit16");
    cyc(1, A_STAT, 32'h0001_0000, 8'h00, 4'h0, "R3 one clears bit16");
    cyc(0, A_STAT, 0, 8'h00, 4'h0, "R9 irq falls after clear");
    cyc(0, A_STAT, 0, 8'hA5, 4'h0, "R2 several mailboxes");
    cyc(1, A_STAT, 32'h0005_0000, 8'h00, 4'h0, "R3 partial clear");
    cyc(1, A_STAT, 32'h00A0_0000, 8'h00, 4'h0, "R3 clear remaining");

    // R4: set beats clear
    cyc(1, A_STAT, 32'h0004_0000, 8'h04, 4'h0, "R4 set and clear same bit");
    cyc(0, A_STAT, 0, 8'h00, 4'h0, "R4 bit18 kept");
    cyc(1, A_STAT, 32'h00FF_0000, 8'h00, 4'h0, "R3 clear all");

    // R5/R6: live mirrors, immune to writes
    cyc(0, A_STAT, 0, 8'h00, 4'hA, "R5 mirror pattern A");
    cyc(1, A_STAT, 32'h0000_3C00, 8'h00, 4'hA, "R6 write ones to mirrors");
    cyc(0, A_STAT, 0, 8'h00, 4'h5, "R5 mirror pattern 5");
    cyc(0, A_STAT, 0, 8'h00, 4'h0, "R5 mirror drops");

    // R9: masking
    cyc(1, A_EN,   32'h0000_1000, 8'h00, 4'h0, "R8 enable only bit12");
    cyc(0, A_STAT, 0, 8'h00, 4'h4, "R9 err bit12 pending");
    cyc(0, A_STAT, 0, 8'h00, 4'h4, "R9 irq from bit12");
    cyc(0, A_STAT, 0, 8'h00, 4'h8, "R9 masked err bit13");
    cyc(0, A_STAT, 0, 8'h10, 4'h0, "R9 masked mailbox4");
    cyc(0, A_STAT, 0, 8'h00, 4'h4, "R9 bit12 again");
    cyc(1, A_EN,   32'h0000_0000, 8'h00, 4'h4, "R9 mask off");
    cyc(0, A_STAT, 0, 8'h00, 4'h4, "R9 irq low after mask");

    // R7: reserved bits in writes
    cyc(1, A_STAT, 32'hFF00_C3FF, 8'h00, 4'h0, "R7 status reserved write");
    cyc(1, A_EN,   32'hFF00_C3FF, 8'h00, 4'h0, "R7 enable reserved write");
    cyc(0, A_EN,   0, 8'h00, 4'h0, "R7 enable still zero");
    cyc(0, A_STAT, 0, 8'h00, 4'h0, "R7 mailbox4 unchanged");

    // R10: unmapped offsets
    cyc(0, 12'h044, 0, 8'h00, 4'hF, "R10 unmapped read");
    cyc(1, 12'h048, 32'hFFFF_FFFF, 8'h00, 4'h0, "R10 unmapped write");
    cyc(0, A_EN,   0, 8'h00, 4'h0, "R10 enable untouched");
    cyc(0, A_STAT, 0, 8'h00, 4'h0, "R10 status untouched");

    @(negedge clk);
    reg_wr_en  = 1'b0;
    mbx_wr_evt = '0;
    repeat (3) @(posedge clk);
    #(CLK_P/2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule